// File: doc/BRIEF.md
# USB Charger-Identification Mode Controller

This block is the digital control for a USB port switch that lets a host present its port as a dedicated charger while the host is asleep. A two-bit mode input picks one of four behaviours. Three modes are fixed: straight USB pass-through between transceiver and connector, a forced short between D+ and D-, or a forced bias-divider network on D+ and D-. The fourth mode is automatic detection, in which a small state machine watches the connector's D- level and picks between the bias network and the short.

The analog side hands over three comparator results that are already digital. They report that D- is at or above the high threshold (about 2.1 V), that D- is above the low threshold (about 0.35 V), and that the divider-select pin is above about 0.4 V. Each result is synchronised and then debounced over a programmable number of clock cycles. The block drives four registered enables: pass-through switch, D+/D- short, bias network, and the pull-up supply of the internal divider. The internal divider's supply is cut whenever the external divider is selected.

Top module: `chgid_ctrl`

## Requirements
- R1: The mode input `mode_sel` is decoded as follows: 2'b11 gives pass-through only, 2'b01 gives the short only, 2'b10 gives the bias network only, and 2'b00 gives automatic detection. A mode change reaches the enables SYNC_STAGES+1 clock edges after it is applied.
- R2: While reset is asserted, and until the synchronised mode input is first valid after release, every enable output is 0 (all-open).
- R3: On entry to automatic mode the bias network is connected first. It stays connected while the filtered high-threshold comparator reads 1.
- R4: In automatic mode with the bias network connected, if the filtered high comparator reads 0 while the filtered low comparator reads 1 (D- has sagged), the block switches to the short.
- R5: In automatic mode with the short connected, if the filtered low comparator reads 0 (D- has collapsed), the block returns to the bias network. It stays there while that comparator remains 0.
- R6: A comparator change is accepted only after it has held for DB_CYCLES consecutive cycles past the synchroniser. Its effect reaches the enables exactly SYNC_STAGES+DB_CYCLES+1 edges after the input changes, and not one edge earlier.
- R7: A comparator pulse shorter than DB_CYCLES cycles restarts the filter count and has no effect on the enables.
- R8: `ipwr_en` is 1 only while the bias network is connected and the filtered divider-select comparator reads 0 (internal divider). It is 0 when the external divider is selected and whenever the bias network is off.
- R9: Any change of the mode input away from 2'b00 aborts automatic detection. A later return to 2'b00 restarts it from the bias-network state, whatever the D- comparators read.
- R10: At most one of `pass_en`, `short_en` and `bias_en` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Mode select: 00 auto, 01 short, 10 bias, 11 pass-through |
| cmp_dm_hi | input | 1 | D- at or above the high threshold |
| cmp_dm_mid | input | 1 | D- above the low threshold |
| cmp_rdp_ext | input | 1 | Divider-select pin above its threshold (external divider) |
| pass_en | output | 1 | Connect transceiver lines straight to connector lines |
| short_en | output | 1 | Short D+ to D- |
| bias_en | output | 1 | Connect the bias-divider network to D+ and D- |
| ipwr_en | output | 1 | Power the internal divider's pull-up |

## Verification
The fixed modes are stepped through in sequence, which separates the decode of each pin value and the latency of the mode path. Automatic detection is first driven with D- high, then with a sag, then a collapse, then a sag again, so each state-machine transition is seen in both directions. A comparator pulse one cycle shorter than the filter and a held change sampled one edge before and at the expected edge pin down the debounce window exactly. A detour through pass-through with D- sagged, followed by a return to auto, shows that detection restarts on the bias network rather than resuming in the short.

// File: rtl/chgid_pkg.sv
package chgid_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_BIAS  = 2'b10,
    MODE_PASS  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_OPEN   = 3'd0,
    ST_PASS   = 3'd1,
    ST_FSHORT = 3'd2,
    ST_FBIAS  = 3'd3,
    ST_ABIAS  = 3'd4,
    ST_ASHORT = 3'd5
  } state_e;

  localparam int CMP_DM_HI   = 0;
  localparam int CMP_DM_MID  = 1;
  localparam int CMP_RDP_EXT = 2;
  localparam int NCMP        = 3;

endpackage

// File: rtl/chgid_rst_sync.sv
module chgid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/chgid_bit_sync.sv
module chgid_bit_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/chgid_debounce.sv
module chgid_debounce #(
  parameter int   CYCLES  = 10000,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q_o
);
  localparam int             CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0]  LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;
  logic          differ;
  logic          cnt_en;

  assign differ = din ^ flt_q;
  // counter only moves while it is counting or must be cleared
  assign cnt_en = differ || (cnt_q != '0);

  always_comb begin
    flt_d = flt_q;
    cnt_d = '0;
    if (differ) begin
      if (cnt_q == LAST) flt_d = din;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= RST_VAL;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign q_o = flt_q;

  // R6: the filtered level flips only at the end of a full count
  p_accept_after_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q != $past(flt_q)) |-> ($past(cnt_q) == LAST));

  // R7: a sample equal to the filtered level leaves it untouched
  p_hold_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(din) == $past(flt_q)) |-> $stable(flt_q));
endmodule

// File: rtl/chgid_mode_fsm.sv
module chgid_mode_fsm
  import chgid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       mode_vld_i,
  input  logic       dm_hi_i,
  input  logic       dm_mid_i,
  output state_e     st_nxt_o
);
  state_e st_q, st_d;
  mode_e  mode;

  assign mode = mode_e'(mode_i);

  always_comb begin
    st_d = st_q;
    if (!mode_vld_i) begin
      st_d = ST_OPEN;
    end else begin
      unique case (mode)
        MODE_PASS:  st_d = ST_PASS;
        MODE_SHORT: st_d = ST_FSHORT;
        MODE_BIAS:  st_d = ST_FBIAS;
        MODE_AUTO: begin
          unique case (st_q)
            ST_ABIAS:  if (!dm_hi_i && dm_mid_i) st_d = ST_ASHORT;
            ST_ASHORT: if (!dm_mid_i)            st_d = ST_ABIAS;
            default:                             st_d = ST_ABIAS;
          endcase
        end
        default: st_d = ST_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OPEN;
    else        st_q <= st_d;
  end

  assign st_nxt_o = st_d;

  // R1: pass-through code selects the pass state
  p_force_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_vld_i && mode == MODE_PASS) |=> (st_q == ST_PASS));

  // R9: entering auto from any other state starts on the bias network
  p_auto_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_vld_i && mode == MODE_AUTO && st_q != ST_ABIAS && st_q != ST_ASHORT)
    |=> (st_q == ST_ABIAS));

  // R4: sag while biased moves to the short
  p_sag_to_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_vld_i && mode == MODE_AUTO && st_q == ST_ABIAS && !dm_hi_i && dm_mid_i)
    |=> (st_q == ST_ASHORT));

  // R5: collapse while shorted returns to the bias network
  p_short_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_vld_i && mode == MODE_AUTO && st_q == ST_ASHORT && !dm_mid_i)
    |=> (st_q == ST_ABIAS));
endmodule

// File: rtl/chgid_out_reg.sv
module chgid_out_reg
  import chgid_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  state_e st_nxt_i,
  input  logic   rdp_ext_i,
  output logic   pass_en_o,
  output logic   short_en_o,
  output logic   bias_en_o,
  output logic   ipwr_en_o
);
  logic pass_d, short_d, bias_d, ipwr_d;

  always_comb begin
    pass_d  = (st_nxt_i == ST_PASS);
    short_d = (st_nxt_i == ST_FSHORT) || (st_nxt_i == ST_ASHORT);
    bias_d  = (st_nxt_i == ST_FBIAS)  || (st_nxt_i == ST_ABIAS);
    ipwr_d  = bias_d && !rdp_ext_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_en_o  <= 1'b0;
      short_en_o <= 1'b0;
      bias_en_o  <= 1'b0;
      ipwr_en_o  <= 1'b0;
    end else begin
      pass_en_o  <= pass_d;
      short_en_o <= short_d;
      bias_en_o  <= bias_d;
      ipwr_en_o  <= ipwr_d;
    end
  end

  // R10: switch enables never overlap
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_en_o, short_en_o, bias_en_o}));

  // R8: divider supply only alongside the bias network
  p_pwr_needs_bias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ipwr_en_o |-> bias_en_o);
endmodule

// File: rtl/chgid_ctrl.sv
module chgid_ctrl
  import chgid_pkg::*;
#(
  parameter int DB_CYCLES   = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       cmp_dm_hi,
  input  logic       cmp_dm_mid,
  input  logic       cmp_rdp_ext,
  output logic       pass_en,
  output logic       short_en,
  output logic       bias_en,
  output logic       ipwr_en
);
  // filtered comparators start as "D- high, D- above low, internal divider"
  localparam logic [NCMP-1:0] CMP_RST = 3'b011;
  localparam int              MW      = 3;

  logic            rst_int_n;
  logic [MW-1:0]   mode_raw, mode_syn;
  logic [NCMP-1:0] cmp_raw, cmp_syn, cmp_flt;
  state_e          st_nxt;

  chgid_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  // top bit is a constant 1 that marks the mode bits as sampled
  assign mode_raw = {1'b1, mode_sel};

  chgid_bit_sync #(.W(MW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_mode_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (mode_raw),
    .dout  (mode_syn)
  );

  assign cmp_raw[CMP_DM_HI]   = cmp_dm_hi;
  assign cmp_raw[CMP_DM_MID]  = cmp_dm_mid;
  assign cmp_raw[CMP_RDP_EXT] = cmp_rdp_ext;

  chgid_bit_sync #(.W(NCMP), .STAGES(SYNC_STAGES), .RST_VAL(CMP_RST)) u_cmp_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (cmp_raw),
    .dout  (cmp_syn)
  );

  for (genvar c = 0; c < NCMP; c++) begin : g_db
    chgid_debounce #(.CYCLES(DB_CYCLES), .RST_VAL(CMP_RST[c])) u_db (
      .clk   (clk),
      .rst_n (rst_int_n),
      .din   (cmp_syn[c]),
      .q_o   (cmp_flt[c])
    );
  end

  chgid_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_i     (mode_syn[1:0]),
    .mode_vld_i (mode_syn[2]),
    .dm_hi_i    (cmp_flt[CMP_DM_HI]),
    .dm_mid_i   (cmp_flt[CMP_DM_MID]),
    .st_nxt_o   (st_nxt)
  );

  chgid_out_reg u_out (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .st_nxt_i   (st_nxt),
    .rdp_ext_i  (cmp_flt[CMP_RDP_EXT]),
    .pass_en_o  (pass_en),
    .short_en_o (short_en),
    .bias_en_o  (bias_en),
    .ipwr_en_o  (ipwr_en)
  );

  // R2: nothing is enabled while the external reset is held
  p_reset_open_r2: assert property (@(posedge clk)
    !rst_n |-> ({pass_en, short_en, bias_en, ipwr_en} == 4'b0000));
endmodule

// File: tb/chgid_ctrl_tb.sv
module chgid_ctrl_tb;
  localparam int DB    = 8;
  localparam int SYNC  = 2;
  localparam int LAT_M = SYNC + 1;
  localparam int LAT_C = SYNC + DB + 1;

  // expected vector order: {pass, short, bias, ipwr}
  localparam logic [3:0] V_OPEN  = 4'b0000;
  localparam logic [3:0] V_PASS  = 4'b1000;
  localparam logic [3:0] V_SHORT = 4'b0100;
  localparam logic [3:0] V_BIASI = 4'b0011;
  localparam logic [3:0] V_BIASE = 4'b0010;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       cmp_dm_hi, cmp_dm_mid, cmp_rdp_ext;
  logic       pass_en, short_en, bias_en, ipwr_en;

  int    n_chk;
  int    n_err;
  bit    done;
  item_t sb_q[$];

  chgid_ctrl #(.DB_CYCLES(DB), .SYNC_STAGES(SYNC)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .cmp_dm_hi   (cmp_dm_hi),
    .cmp_dm_mid  (cmp_dm_mid),
    .cmp_rdp_ext (cmp_rdp_ext),
    .pass_en     (pass_en),
    .short_en    (short_en),
    .bias_en     (bias_en),
    .ipwr_en     (ipwr_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = sb_q.pop_front();
      act = {pass_en, short_en, bias_en, ipwr_en};
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  // expectation for the outputs after the next rising edge
  task automatic chk(input logic [3:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 0;
    rst_n       = 1'b0;
    mode_sel    = 2'b11;
    cmp_dm_hi   = 1'b1;
    cmp_dm_mid  = 1'b1;
    cmp_rdp_ext = 1'b0;
    tick(3);
    chk(V_OPEN, "R2 outputs open in reset");
    rst_n = 1'b1;
    chk(V_OPEN, "R2 still open just after release");
    tick(6);
    chk(V_PASS, "R1 mode 11 pass-through");

    mode_sel = 2'b01;
    tick(LAT_M - 2);
    chk(V_PASS, "R1 mode change not yet visible");
    chk(V_SHORT, "R1 mode 01 short");

    mode_sel = 2'b10;
    tick(LAT_M - 1);
    chk(V_BIASI, "R1 R8 mode 10 bias internal divider");

    cmp_rdp_ext = 1'b1;
    tick(LAT_C - 1);
    chk(V_BIASE, "R8 external divider cuts supply");
    cmp_rdp_ext = 1'b0;
    tick(LAT_C - 1);
    chk(V_BIASI, "R8 internal divider powered again");

    mode_sel = 2'b00;
    tick(LAT_M - 1);
    chk(V_BIASI, "R3 auto starts on bias network");
    tick(20);
    chk(V_BIASI, "R3 bias held while DM high");

    // pulse one cycle shorter than the filter
    cmp_dm_hi = 1'b0;
    tick(DB - 1);
    cmp_dm_hi = 1'b1;
    tick(LAT_C + 2);
    chk(V_BIASI, "R7 short DM dip rejected");

    cmp_dm_hi = 1'b0;
    tick(LAT_C - 2);
    chk(V_BIASI, "R6 one edge before debounce expiry");
    chk(V_SHORT, "R4 R6 sag switches to short");
    tick(10);
    chk(V_SHORT, "R4 short held while DM above low level");

    cmp_dm_mid = 1'b0;
    tick(LAT_C - 1);
    chk(V_BIASI, "R5 collapse returns to bias");
    tick(10);
    chk(V_BIASI, "R5 bias held while DM collapsed");

    cmp_dm_mid = 1'b1;
    tick(LAT_C - 1);
    chk(V_SHORT, "R4 second sag shorts again");

    mode_sel = 2'b11;
    tick(LAT_M - 1);
    chk(V_PASS, "R9 mode change aborts auto");
    mode_sel = 2'b00;
    tick(LAT_M - 1);
    chk(V_BIASI, "R9 auto restarts on bias network");
    chk(V_SHORT, "R4 R9 sagged DM then shorts");

    rst_n = 1'b0;
    #1;
    chk(V_OPEN, "R2 async reset reopens everything");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule